// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the serial slave side of a byte-organized nonvolatile memory model. It oversamples chip select, serial clock, serial data in and the pause input with a fast system clock, detects serial clock edges in that domain, and decodes an 8-bit command followed, where needed, by a 16-bit address and a stream of data bytes. Every bit travels most significant first. Incoming bits are taken on rising serial clock edges, and outgoing bits change on falling ones. Serial clock idle low and idle high both work.

Array reads go to a synchronous memory port with one cycle of latency. The block fetches the next byte while the current one is shifting out, so a read streams without gaps and wraps from the top address to zero. Write bytes, status writes and write-enable requests leave as single-cycle pulses for a page-write sequencer. The serial output has its own enable, so the pin can float. The block also handles a pause that freezes a transfer in place, a lockout after a bad command, and the restriction to status reads while an internal write cycle runs.

Top module: `spinv_front`

## Requirements
- R1: The command is the first byte after select. Its upper nibble must be 0000, bit 3 is ignored, and bits 2..0 select the command: 110 set-enable, 100 clear-enable, 101 status read, 001 status write, 011 array read, 010 array write.
- R2: On the eighth command bit, set-enable pulses `wel_set` and clear-enable pulses `wel_clr`, each for one cycle.
- R3: If the upper nibble is nonzero or bits 2..0 are 000 or 111, the command is invalid. The block then takes no further bits, raises no pulse, issues no memory read and keeps `so_oe` low until chip select rises and falls again.
- R4: Array read and array write take a 16-bit address. Address bits at AW and above are ignored. A read outputs data from that byte onwards with no gap. The address increments after each byte and wraps from 2^AW-1 to 0.
- R5: Status read shifts out `stat_i` and repeats it for as long as clocking continues.
- R6: Array write pulses `wr_byte_vld` with the address and data after each complete data byte. Only the low PAGE_W address bits increment, wrapping inside the page. `wr_done` pulses once when chip select rises on a byte boundary after at least one data byte.
- R7: Status write pulses `stat_wr_vld` with the first data byte after the command.
- R8: Taking `hold_n` low while the serial clock is low pauses the transfer. `so_oe` drops, and serial clock and data in are ignored. Raising `hold_n` while the serial clock is low resumes at the same bit.
- R9: While chip select is high, `so_oe` is low and input bits are ignored. Every command starts on a falling chip select.
- R10: While `busy_i` is high when the command completes, every command except status read behaves as invalid (R3).
- R11: Serial clock idle low and idle high both work. Output bits change on falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (low means high impedance) |
| busy_i | input | 1 | Internal write cycle in progress |
| stat_i | input | 8 | Status byte returned by status read |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | 8 | Memory read data, one cycle after the request |
| wel_set | output | 1 | Set write-enable latch pulse |
| wel_clr | output | 1 | Clear write-enable latch pulse |
| stat_wr_vld | output | 1 | Status write pulse |
| stat_wr_data | output | 8 | Status write byte |
| wr_byte_vld | output | 1 | Write byte pulse |
| wr_byte_addr | output | AW | Write byte address |
| wr_byte_data | output | 8 | Write byte data |
| wr_done | output | 1 | Write command closed on a byte boundary |

## Verification
The bench reads across the top of the array. A wrong wrap, or a design that honours the upper address bits, returns data from the wrong address. It writes across a page boundary, where a carry into the upper address bits would move bytes to the next page, and it ends one write part-way through a byte to catch a `wr_done` that ignores the byte boundary. It pauses a read mid-byte while toggling the serial clock: a design that keeps counting edges or keeps driving the output returns a shifted byte or shows the enable high. Invalid commands, busy lockout and traffic while deselected are checked for stray pulses, stray memory reads and a driven output.

// File: rtl/spinv_pkg.sv
package spinv_pkg;
   localparam int ADDR_BITS = 16;

   localparam logic [2:0] CMD_WEL_SET = 3'b110;
   localparam logic [2:0] CMD_WEL_CLR = 3'b100;
   localparam logic [2:0] CMD_STAT_RD = 3'b101;
   localparam logic [2:0] CMD_STAT_WR = 3'b001;
   localparam logic [2:0] CMD_ARR_RD  = 3'b011;
   localparam logic [2:0] CMD_ARR_WR  = 3'b010;

   typedef enum logic [3:0] {
      ST_IDLE, ST_CMD, ST_ADDR, ST_RDAT, ST_WDAT, ST_SWR, ST_SRD, ST_DONE, ST_LOCK
   } spinv_st_e;

   function automatic logic cmd_known(input logic [2:0] c);
      return (c != 3'b000) && (c != 3'b111);
   endfunction
endpackage

// File: rtl/spinv_sync.sv
module spinv_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spinv_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spinv_outbuf.sv
module spinv_outbuf (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       adv,
   input  logic       ld_cur,
   input  logic [7:0] cur_d,
   input  logic       ld_nxt,
   input  logic [7:0] nxt_d,
   input  logic       refill_stat,
   input  logic [7:0] stat_d,
   output logic       so_bit,
   output logic       swap
);
   logic [2:0] bi;
   logic [7:0] cur, nxt;
   logic       so_q;

   assign swap   = adv && (bi == 3'd7);
   assign so_bit = so_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bi   <= '0;
         cur  <= '0;
         nxt  <= '0;
         so_q <= 1'b0;
      end else begin
         if (clr)      bi <= '0;
         else if (adv) bi <= bi + 3'd1;
         if (adv) so_q <= cur[3'd7 - bi];
         if (ld_cur)    cur <= cur_d;
         else if (swap) cur <= refill_stat ? stat_d : nxt;
         if (ld_nxt) nxt <= nxt_d;
      end
   end

   // R4: a byte boundary always restarts at the MSB position
   assert_swap_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (swap && !clr) |=> (bi == 3'd0));
endmodule

// File: rtl/spinv_front.sv
module spinv_front
   import spinv_pkg::*;
#(
   parameter int AW          = 15,
   parameter int PAGE_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          sck,
   input  logic          si,
   input  logic          hold_n,
   output logic          so,
   output logic          so_oe,
   input  logic          busy_i,
   input  logic [7:0]    stat_i,
   output logic          mem_rd_en,
   output logic [AW-1:0] mem_rd_addr,
   input  logic [7:0]    mem_rd_data,
   output logic          wel_set,
   output logic          wel_clr,
   output logic          stat_wr_vld,
   output logic [7:0]    stat_wr_data,
   output logic          wr_byte_vld,
   output logic [AW-1:0] wr_byte_addr,
   output logic [7:0]    wr_byte_data,
   output logic          wr_done
);
   localparam int SHW = AW - 1;

   generate
      if (AW < 8 || AW > ADDR_BITS) begin : g_bad_aw
         $error("spinv_front: AW must lie in 8..16");
      end
      if (PAGE_W < 1 || PAGE_W >= AW) begin : g_bad_page
         $error("spinv_front: PAGE_W must lie in 1..AW-1");
      end
   endgenerate

   // synchronised pins: {cs_n, sck, si, hold_n}
   logic s_csn, s_sck, s_si, s_hold_n;
   spinv_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si, hold_n}),
      .q({s_csn, s_sck, s_si, s_hold_n}));

   spinv_st_e      state;
   logic [3:0]     cnt;
   logic [SHW-1:0] sh;
   logic           is_rd, wany, paused, cs_q, sck_q;
   logic [AW-1:0]  waddr, ptr;
   logic           rq_next, rsp_first, rsp_next, st_ld;
   logic           rise, fall, cs_fall, rq_first, swap, out_mode;
   logic [2:0]     code;
   logic [AW-1:0]  addr_in;
   logic [7:0]     data_in;

   assign cs_fall  = cs_q && !s_csn;
   assign rise     = !sck_q && s_sck && !paused && !s_csn;
   assign fall     = sck_q && !s_sck && !paused && !s_csn;
   assign code     = {sh[1:0], s_si};
   assign addr_in  = {sh, s_si};
   assign data_in  = {sh[6:0], s_si};
   assign out_mode = (state == ST_RDAT) || (state == ST_SRD);

   assign rq_first    = (state == ST_ADDR) && rise && (cnt == 4'd15) && is_rd;
   assign mem_rd_en   = rq_first || rq_next;
   assign mem_rd_addr = rq_first ? addr_in : ptr;
   assign so_oe       = !s_csn && !paused && out_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;  cnt <= '0;  sh <= '0;  is_rd <= 1'b0;  wany <= 1'b0;
         paused <= 1'b0;  cs_q <= 1'b1;  sck_q <= 1'b0;  waddr <= '0;  ptr <= '0;
         rq_next <= 1'b0;  rsp_first <= 1'b0;  rsp_next <= 1'b0;  st_ld <= 1'b0;
         wel_set <= 1'b0;  wel_clr <= 1'b0;  stat_wr_vld <= 1'b0;  stat_wr_data <= '0;
         wr_byte_vld <= 1'b0;  wr_byte_addr <= '0;  wr_byte_data <= '0;  wr_done <= 1'b0;
      end else begin
         wel_set <= 1'b0;  wel_clr <= 1'b0;  stat_wr_vld <= 1'b0;
         wr_byte_vld <= 1'b0;  wr_done <= 1'b0;  st_ld <= 1'b0;
         cs_q      <= s_csn;
         sck_q     <= s_sck;
         rsp_first <= rq_first;
         rsp_next  <= rq_next;
         rq_next   <= rsp_first || (swap && state == ST_RDAT);
         if (rq_first)     ptr <= addr_in + 1'b1;
         else if (rq_next) ptr <= ptr + 1'b1;

         if (s_csn)        paused <= 1'b0;
         else if (!s_sck)  paused <= !s_hold_n;

         if (s_csn) begin
            if (state == ST_WDAT && wany && cnt == 4'd0) wr_done <= 1'b1;
            state <= ST_IDLE;
         end else if (cs_fall) begin
            state <= ST_CMD;
            cnt   <= '0;
         end else if (rise) begin
            sh  <= {sh[SHW-2:0], s_si};
            cnt <= cnt + 4'd1;
            case (state)
               ST_CMD: if (cnt == 4'd7) begin
                  cnt <= '0;
                  if (sh[6:3] != 4'b0000 || !cmd_known(code) ||
                      (busy_i && code != CMD_STAT_RD)) begin
                     state <= ST_LOCK;
                  end else begin
                     case (code)
                        CMD_WEL_SET: begin wel_set <= 1'b1; state <= ST_DONE; end
                        CMD_WEL_CLR: begin wel_clr <= 1'b1; state <= ST_DONE; end
                        CMD_STAT_RD: begin st_ld <= 1'b1;   state <= ST_SRD;  end
                        CMD_STAT_WR: state <= ST_SWR;
                        CMD_ARR_RD:  begin is_rd <= 1'b1;   state <= ST_ADDR; end
                        default:     begin is_rd <= 1'b0;   state <= ST_ADDR; end
                     endcase
                  end
               end
               ST_ADDR: if (cnt == 4'd15) begin
                  cnt <= '0;
                  if (is_rd) state <= ST_RDAT;
                  else begin
                     state <= ST_WDAT;
                     waddr <= addr_in;
                     wany  <= 1'b0;
                  end
               end
               ST_WDAT: if (cnt == 4'd7) begin
                  cnt          <= '0;
                  wr_byte_vld  <= 1'b1;
                  wr_byte_addr <= waddr;
                  wr_byte_data <= data_in;
                  waddr        <= {waddr[AW-1:PAGE_W], waddr[PAGE_W-1:0] + 1'b1};
                  wany         <= 1'b1;
               end
               ST_SWR: if (cnt == 4'd7) begin
                  stat_wr_vld  <= 1'b1;
                  stat_wr_data <= data_in;
                  state        <= ST_DONE;
               end
               default: ;
            endcase
         end
      end
   end

   spinv_outbuf u_out (
      .clk(clk), .rst_n(rst_n), .clr(s_csn), .adv(fall && out_mode),
      .ld_cur(rsp_first || st_ld), .cur_d(rsp_first ? mem_rd_data : stat_i),
      .ld_nxt(rsp_next), .nxt_d(mem_rd_data),
      .refill_stat(state == ST_SRD), .stat_d(stat_i),
      .so_bit(so), .swap(swap));

   // R9: deselected for two synchroniser delays means the output floats
   assert_desel_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe);

   // R3: a locked-out transfer raises nothing
   assert_lock_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOCK) |-> (!so_oe && !mem_rd_en && !wr_byte_vld && !wel_set && !stat_wr_vld));

   // R8: a paused transfer keeps its bit position and shift contents
   assert_pause_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && $past(paused) && !s_csn && !$past(s_csn)) |-> ($stable(cnt) && $stable(sh)));

   // R6: page writes never touch the upper address bits
   assert_page_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WDAT && $past(state) == ST_WDAT) |->
      (waddr[AW-1:PAGE_W] == $past(waddr[AW-1:PAGE_W])));

   // R2: sequencer pulses are mutually exclusive
   assert_pulse_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wel_set, wel_clr, stat_wr_vld, wr_byte_vld, wr_done}));
endmodule

// File: tb/spinv_front_tb.sv
module spinv_front_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 15;
   localparam int HALF = 6;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
   logic so, so_oe, busy_i = 1'b0;
   logic [7:0] stat_i = 8'h00;
   logic mem_rd_en;
   logic [AW-1:0] mem_rd_addr;
   logic [7:0] mem_rd_data;
   logic wel_set, wel_clr, stat_wr_vld, wr_byte_vld, wr_done;
   logic [7:0] stat_wr_data, wr_byte_data;
   logic [AW-1:0] wr_byte_addr;

   int checks = 0, failures = 0;
   int n_set = 0, n_clr = 0, n_swr = 0, n_wb = 0, n_done = 0, n_rd = 0;
   logic [7:0] last_swr;
   logic [AW-1:0] wb_addr [16];
   logic [7:0]    wb_data [16];
   bit mode3 = 1'b0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spinv_front #(.AW(AW), .PAGE_W(6), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
      .so(so), .so_oe(so_oe), .busy_i(busy_i), .stat_i(stat_i),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .wel_set(wel_set), .wel_clr(wel_clr), .stat_wr_vld(stat_wr_vld),
      .stat_wr_data(stat_wr_data), .wr_byte_vld(wr_byte_vld), .wr_byte_addr(wr_byte_addr),
      .wr_byte_data(wr_byte_data), .wr_done(wr_done));

   function automatic logic [7:0] mval(input logic [AW-1:0] a);
      return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
   endfunction

   always_ff @(posedge clk) mem_rd_data <= mval(mem_rd_addr);

   always @(posedge clk) begin
      if (wel_set) n_set <= n_set + 1;
      if (wel_clr) n_clr <= n_clr + 1;
      if (stat_wr_vld) begin n_swr <= n_swr + 1; last_swr <= stat_wr_data; end
      if (wr_byte_vld) begin
         wb_addr[n_wb % 16] <= wr_byte_addr;
         wb_data[n_wb % 16] <= wr_byte_data;
         n_wb <= n_wb + 1;
      end
      if (wr_done) n_done <= n_done + 1;
      if (mem_rd_en) n_rd <= n_rd + 1;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sel();
      sck = mode3; cs_n = 1'b0; wt(HALF);
   endtask

   task automatic desel();
      wt(HALF); cs_n = 1'b1; wt(3 * HALF);
   endtask

   // shifts out tx[7..8-n], collects so into rx[7..8-n]
   task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx,
                        output bit oe_all, output bit oe_any);
      rx = '0; oe_all = 1'b1; oe_any = 1'b0;
      for (int i = 7; i >= 8 - n; i--) begin
         if (mode3) sck = 1'b0;
         si = tx[i];
         wt(HALF);
         rx[i] = so;
         oe_all = oe_all & so_oe;
         oe_any = oe_any | so_oe;
         sck = 1'b1;
         wt(HALF);
         if (!mode3) sck = 1'b0;
      end
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx,
                        output bit oe_all, output bit oe_any);
      xbits(tx, 8, rx, oe_all, oe_any);
   endtask

   task automatic send_addr(input logic [15:0] a);
      logic [7:0] r; bit oa, on;
      xbyte(a[15:8], r, oa, on);
      xbyte(a[7:0], r, oa, on);
   endtask

   task automatic t_reset();
      chk(so_oe == 1'b0, "R9 reset oe", so_oe, 0);
      chk(n_set + n_clr + n_wb + n_swr == 0, "R9 reset pulses", n_set + n_clr + n_wb, 0);
   endtask

   task automatic t_enable();
      logic [7:0] r; bit oa, on; int s0, c0;
      s0 = n_set; c0 = n_clr;
      sel(); xbyte(8'h06, r, oa, on); desel();
      chk(n_set == s0 + 1, "R2 set-enable pulse", n_set - s0, 1);
      sel(); xbyte(8'h0E, r, oa, on); desel();
      chk(n_set == s0 + 2, "R1 bit3 ignored", n_set - s0, 2);
      sel(); xbyte(8'h04, r, oa, on); desel();
      chk(n_clr == c0 + 1, "R2 clear-enable pulse", n_clr - c0, 1);
   endtask

   task automatic t_read(input bit m3, input logic [7:0] op, input logic [15:0] a,
                         input int nb, input string tag);
      logic [7:0] r; bit oa, on;
      logic [AW-1:0] ea;
      mode3 = m3;
      ea = a[AW-1:0];
      sel(); xbyte(op, r, oa, on); send_addr(a);
      for (int k = 0; k < nb; k++) begin
         xbyte(8'h00, r, oa, on);
         chk(r == mval(ea) && oa, tag, r, mval(ea));
         ea = ea + 1'b1;
      end
      desel();
      mode3 = 1'b0;
   endtask

   task automatic t_status();
      logic [7:0] r; bit oa, on;
      stat_i = 8'hA5;
      sel(); xbyte(8'h05, r, oa, on);
      xbyte(8'h00, r, oa, on);
      chk(r == 8'hA5 && oa, "R5 status first", r, 8'hA5);
      xbyte(8'h00, r, oa, on);
      chk(r == 8'hA5 && oa, "R5 status repeat", r, 8'hA5);
      desel();
   endtask

   task automatic t_stat_write();
      logic [7:0] r; bit oa, on; int s0;
      s0 = n_swr;
      sel(); xbyte(8'h01, r, oa, on); xbyte(8'h8C, r, oa, on); desel();
      chk(n_swr == s0 + 1, "R7 status write count", n_swr - s0, 1);
      chk(last_swr == 8'h8C, "R7 status write data", last_swr, 8'h8C);
   endtask

   task automatic t_page_write();
      logic [7:0] r; bit oa, on; int b0, d0;
      b0 = n_wb; d0 = n_done;
      sel(); xbyte(8'h02, r, oa, on); send_addr(16'h923E);
      xbyte(8'h11, r, oa, on); xbyte(8'h22, r, oa, on); xbyte(8'h33, r, oa, on);
      chk(!on, "R6 no output in write", on, 0);
      desel();
      chk(n_wb == b0 + 3, "R6 byte count", n_wb - b0, 3);
      chk(wb_addr[b0 % 16] == 15'h123E && wb_data[b0 % 16] == 8'h11, "R6 first byte",
          wb_addr[b0 % 16], 15'h123E);
      chk(wb_addr[(b0 + 1) % 16] == 15'h123F, "R6 second addr", wb_addr[(b0 + 1) % 16], 15'h123F);
      chk(wb_addr[(b0 + 2) % 16] == 15'h1200 && wb_data[(b0 + 2) % 16] == 8'h33,
          "R6 page wrap", wb_addr[(b0 + 2) % 16], 15'h1200);
      chk(n_done == d0 + 1, "R6 done on boundary", n_done - d0, 1);
   endtask

   task automatic t_partial_write();
      logic [7:0] r; bit oa, on; int b0, d0;
      b0 = n_wb; d0 = n_done;
      sel(); xbyte(8'h02, r, oa, on); send_addr(16'h0040);
      xbyte(8'h77, r, oa, on); xbits(8'hA0, 3, r, oa, on); desel();
      chk(n_wb == b0 + 1, "R6 partial byte count", n_wb - b0, 1);
      chk(n_done == d0, "R6 no done off boundary", n_done - d0, 0);
   endtask

   task automatic t_invalid();
      logic [7:0] r; bit oa, on, any; int s0, r0;
      s0 = n_set; r0 = n_rd; any = 1'b0;
      sel(); xbyte(8'h80, r, oa, on); xbyte(8'h06, r, oa, on); any |= on;
      xbyte(8'h03, r, oa, on); any |= on; desel();
      sel(); xbyte(8'h07, r, oa, on); xbyte(8'h00, r, oa, on); any |= on; desel();
      chk(!any, "R3 output stays off", any, 0);
      chk(n_set == s0 && n_rd == r0, "R3 no pulses", n_set - s0 + n_rd - r0, 0);
      sel(); xbyte(8'h06, r, oa, on); desel();
      chk(n_set == s0 + 1, "R3 reselect recovers", n_set - s0, 1);
   endtask

   task automatic t_busy();
      logic [7:0] r; bit oa, on; int s0, r0;
      busy_i = 1'b1; stat_i = 8'hFF;
      s0 = n_set; r0 = n_rd;
      sel(); xbyte(8'h06, r, oa, on); desel();
      chk(n_set == s0, "R10 enable ignored", n_set - s0, 0);
      sel(); xbyte(8'h03, r, oa, on); send_addr(16'h0000); xbyte(8'h00, r, oa, on); desel();
      chk(!on && n_rd == r0, "R10 read ignored", n_rd - r0, 0);
      sel(); xbyte(8'h05, r, oa, on); xbyte(8'h00, r, oa, on); desel();
      chk(r == 8'hFF && oa, "R10 status allowed", r, 8'hFF);
      busy_i = 1'b0;
   endtask

   task automatic t_hold();
      logic [7:0] r, hi, lo; bit oa, on, oa2, on2;
      sel(); xbyte(8'h03, r, oa, on); send_addr(16'h0200);
      xbyte(8'h00, r, oa, on);
      chk(r == mval(15'h0200), "R8 byte before pause", r, mval(15'h0200));
      xbits(8'h00, 4, hi, oa, on);
      hold_n = 1'b0; wt(HALF);
      for (int k = 0; k < 3; k++) begin
         si = k[0]; sck = 1'b1; wt(HALF); sck = 1'b0; wt(HALF);
      end
      chk(so_oe == 1'b0, "R8 output floats while paused", so_oe, 0);
      hold_n = 1'b1; wt(HALF);
      xbits(8'h00, 4, lo, oa2, on2);
      r = {hi[7:4], lo[7:4]};
      chk(r == mval(15'h0201) && oa && oa2, "R8 resume same bit", r, mval(15'h0201));
      xbyte(8'h00, r, oa, on);
      chk(r == mval(15'h0202), "R8 stream continues", r, mval(15'h0202));
      desel();
   endtask

   task automatic t_deselected();
      int s0;
      s0 = n_set;
      for (int i = 7; i >= 0; i--) begin
         si = (8'h06 >> i) & 1; sck = 1'b1; wt(HALF);
         chk(so_oe == 1'b0, "R9 output off when deselected", so_oe, 0);
         sck = 1'b0; wt(HALF);
      end
      chk(n_set == s0, "R9 input ignored when deselected", n_set - s0, 0);
   endtask

   initial begin
      wt(5); rst_n = 1'b1; wt(5);
      t_reset();
      t_enable();
      t_read(1'b0, 8'h03, 16'h0100, 3, "R4 read idle-low clock");
      t_read(1'b1, 8'h0B, 16'h0A0B, 2, "R11 read idle-high clock");
      t_read(1'b0, 8'h03, 16'hFFFF, 2, "R4 top wrap and upper bits");
      t_status();
      t_stat_write();
      t_page_write();
      t_partial_write();
      t_invalid();
      t_busy();
      t_hold();
      t_deselected();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule